// File: doc/BRIEF.md
# Countdown Timer Bank

This block is a memory-mapped timer peripheral. It holds three down-counting channels that reload themselves, plus one free-running up-counter that serves as a time reference. Channels 1 and 2 are 16 bits wide and channel 3 is 32 bits wide. The reference counter is 40 bits wide.

Each down-counter steps on one of two shared tick inputs, a slow one or a fast one, as its control register selects. When it steps from zero it raises a level interrupt, and that interrupt stays high until software clears it. The reference counter steps on its own tick input. It never interrupts, and software reads it as two 32-bit words.

Software reaches the block through a simple word bus: an address, a write strobe, write data and registered read data. The usual setup sequence is:
1. Write the control register with the channel disabled.
2. Write the start value.
3. Write the control register again with the enable bit set.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every register reads zero and all interrupt outputs are low.
- R2: Register offsets are fixed. Channel 1 uses 0x00/0x04/0x08/0x0C, channel 2 uses 0x20–0x2C and channel 3 uses 0x80–0x8C; within each group the order is load, value, control, clear. The reference counter reads at 0x60 (low word) and 0x64 (high word). Read data appears on the clock edge after the address is presented. Unmapped offsets read zero.
- R3: Channels 1 and 2 keep 16 bits of load and count, and their upper 16 bits read as zero. Channel 3 keeps all 32 bits.
- R4: An enabled channel decrements by one on each selected tick. A disabled channel holds its count.
- R5: Control bit 3 picks the tick source: 1 selects the fast tick and 0 selects the slow tick. Pulses on the other tick have no effect.
- R6: With control bit 6 set (periodic mode), a tick at count zero reloads the count from the load register and raises the channel interrupt.
- R7: With control bit 6 clear (free mode), a tick at count zero wraps the count to all ones of the channel width and raises the interrupt.
- R8: Writing load while the channel is disabled (control bit 7 clear) sets the count at once. Writing load while the channel is enabled leaves the count unchanged until the next selected tick, and that tick loads the new value.
- R9: The interrupt is sticky. A write of any data to the clear offset drops it. If an underflow happens in the same cycle as a clear write, the interrupt stays high.
- R10: Writes to a value offset are ignored.
- R11: Bit 8 of the 0x64 word enables the reference counter and reads back. While that bit is clear, the counter is zero. While it is set, the counter adds one per reference tick. The count reads as bits 31:0 at 0x60 and bits 39:32 in bits 7:0 of 0x64. Other written bits of 0x64 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| tick_slow | input | 1 | Slow count enable pulse |
| tick_fast | input | 1 | Fast count enable pulse |
| tick_ref | input | 1 | Reference counter enable pulse |
| irq | output | 3 | Per-channel underflow interrupt, bit 0 = channel 1 |

## Verification
A register write takes effect at the edge that samples the strobe. Read data for an address is valid after the following edge, so a read costs one full cycle between presenting the address and sampling. An underflow tick sets the interrupt at the same edge that updates the count. The bench therefore checks interrupts right after the tick cycle and reads the count one cycle later. All inputs change on falling edges and all outputs are sampled on the falling edge after the edge that produces them, so each check lands exactly one register stage after its cause.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int N_CHAN       = 3;
  localparam int CTL_EN_BIT   = 7;
  localparam int CTL_PER_BIT  = 6;
  localparam int CTL_FAST_BIT = 3;
  localparam int REF_EN_BIT   = 8;

  localparam logic [7:0] OFS_LOAD = 8'h00;
  localparam logic [7:0] OFS_VAL  = 8'h04;
  localparam logic [7:0] OFS_CTL  = 8'h08;
  localparam logic [7:0] OFS_CLR  = 8'h0C;
  localparam logic [7:0] REF_LO   = 8'h60;
  localparam logic [7:0] REF_HI   = 8'h64;

  typedef struct packed {
    logic en;
    logic periodic;
    logic fast;
  } chan_ctl_t;

  function automatic logic [7:0] chan_base(int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h20;
      default: return 8'h80;
    endcase
  endfunction

  function automatic logic [31:0] ctl_word(chan_ctl_t c);
    logic [31:0] w;
    w = '0;
    w[CTL_EN_BIT]   = c.en;
    w[CTL_PER_BIT]  = c.periodic;
    w[CTL_FAST_BIT] = c.fast;
    return w;
  endfunction

endpackage

// File: rtl/tmr_down_chan.sv
module tmr_down_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_slow,
  input  logic             tick_fast,
  input  logic             wr_load,
  input  logic             wr_ctl,
  input  logic             wr_clr,
  input  logic [CNT_W-1:0] load_data,
  input  chan_ctl_t        ctl_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] load_o,
  output chan_ctl_t        ctl_o,
  output logic             irq_o,
  output logic             uflow_o
);

  logic pend_q;
  logic step;

  assign step    = ctl_o.en & (ctl_o.fast ? tick_fast : tick_slow);
  assign uflow_o = step & ~pend_q & (cnt_o == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      load_o <= '0;
      ctl_o  <= '0;
      irq_o  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_ctl)  ctl_o  <= ctl_data;
      if (wr_load) load_o <= load_data;

      if (wr_load && !ctl_o.en) begin
        cnt_o <= load_data;
      end else if (step) begin
        if (pend_q)                cnt_o <= load_o;
        else if (cnt_o == '0)      cnt_o <= ctl_o.periodic ? load_o : '1;
        else                       cnt_o <= cnt_o - 1'b1;
      end

      if (wr_load)   pend_q <= ctl_o.en;
      else if (step) pend_q <= 1'b0;

      if (uflow_o)     irq_o <= 1'b1;
      else if (wr_clr) irq_o <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr_ref_count.sv
module tmr_ref_count #(
  parameter int REF_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_hi,
  input  logic             en_data,
  output logic [REF_W-1:0] cnt_o,
  output logic             en_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      en_o  <= 1'b0;
    end else begin
      if (wr_hi) en_o <= en_data;
      if (!en_o)     cnt_o <= '0;
      else if (tick) cnt_o <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int REF_W    = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_slow,
  input  logic              tick_fast,
  input  logic              tick_ref,
  output logic [N_CHAN-1:0] irq
);

  localparam int REF_HI_W = REF_W - DATA_W;

  logic [N_CHAN-1:0][DATA_W-1:0] cnt_ext;
  logic [N_CHAN-1:0][DATA_W-1:0] load_ext;
  logic [N_CHAN-1:0][DATA_W-1:0] ctl_ext;
  logic [N_CHAN-1:0]             uflow;
  logic [N_CHAN-1:0]             chan_en;
  logic [N_CHAN-1:0]             irq_q;
  chan_ctl_t                     ctl_in;

  logic [REF_W-1:0]  ref_cnt;
  logic              ref_en;
  logic [DATA_W-1:0] ref_hi_word;
  logic [DATA_W-1:0] rd_next;

  assign ctl_in = '{en:       bus_wdata[CTL_EN_BIT],
                    periodic: bus_wdata[CTL_PER_BIT],
                    fast:     bus_wdata[CTL_FAST_BIT]};

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    localparam int W = (g == N_CHAN - 1) ? WIDE_W : NARROW_W;
    localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(chan_base(g) + OFS_LOAD);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(chan_base(g) + OFS_CTL);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(chan_base(g) + OFS_CLR);

    logic [W-1:0] cnt_w;
    logic [W-1:0] load_w;
    chan_ctl_t    ctl_w;

    tmr_down_chan #(.CNT_W(W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .tick_slow (tick_slow),
      .tick_fast (tick_fast),
      .wr_load   (bus_we && (bus_addr == A_LOAD)),
      .wr_ctl    (bus_we && (bus_addr == A_CTL)),
      .wr_clr    (bus_we && (bus_addr == A_CLR)),
      .load_data (bus_wdata[W-1:0]),
      .ctl_data  (ctl_in),
      .cnt_o     (cnt_w),
      .load_o    (load_w),
      .ctl_o     (ctl_w),
      .irq_o     (irq_q[g]),
      .uflow_o   (uflow[g])
    );

    assign cnt_ext[g]  = DATA_W'(cnt_w);
    assign load_ext[g] = DATA_W'(load_w);
    assign ctl_ext[g]  = DATA_W'(ctl_word(ctl_w));
    assign chan_en[g]  = ctl_w.en;
  end

  tmr_ref_count #(.REF_W(REF_W)) u_ref (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_ref),
    .wr_hi   (bus_we && (bus_addr == ADDR_W'(REF_HI))),
    .en_data (bus_wdata[REF_EN_BIT]),
    .cnt_o   (ref_cnt),
    .en_o    (ref_en)
  );

  always_comb begin
    ref_hi_word = '0;
    ref_hi_word[REF_HI_W-1:0] = ref_cnt[REF_W-1:DATA_W];
    ref_hi_word[REF_EN_BIT]   = ref_en;
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < N_CHAN; i++) begin
      if (bus_addr == ADDR_W'(chan_base(i) + OFS_LOAD)) rd_next = load_ext[i];
      if (bus_addr == ADDR_W'(chan_base(i) + OFS_VAL))  rd_next = cnt_ext[i];
      if (bus_addr == ADDR_W'(chan_base(i) + OFS_CTL))  rd_next = ctl_ext[i];
    end
    if (bus_addr == ADDR_W'(REF_LO)) rd_next = ref_cnt[DATA_W-1:0];
    if (bus_addr == ADDR_W'(REF_HI)) rd_next = ref_hi_word;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  assign irq = irq_q;

endmodule

// File: rtl/tmr_bank_checks.sv
module tmr_bank_checks
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int REF_W  = 40
) (
  input logic                          clk,
  input logic                          rst,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic                          bus_we,
  input logic                          tick_ref,
  input logic [N_CHAN-1:0]             irq,
  input logic [N_CHAN-1:0]             uflow,
  input logic [N_CHAN-1:0]             chan_en,
  input logic [N_CHAN-1:0][DATA_W-1:0] cnt_ext,
  input logic                          ref_en,
  input logic [REF_W-1:0]              ref_cnt
);

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chk
    logic clr_wr;
    logic load_wr;
    assign clr_wr  = bus_we && (bus_addr == ADDR_W'(chan_base(g) + OFS_CLR));
    assign load_wr = bus_we && (bus_addr == ADDR_W'(chan_base(g) + OFS_LOAD));

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
      (irq[g] && !clr_wr) |=> irq[g]);

    a_r9_clear_drops: assert property (@(posedge clk) disable iff (rst)
      (clr_wr && !uflow[g]) |=> !irq[g]);

    a_r6_uflow_raises: assert property (@(posedge clk) disable iff (rst)
      uflow[g] |=> irq[g]);

    a_r4_disabled_holds: assert property (@(posedge clk) disable iff (rst)
      (!chan_en[g] && !load_wr) |=> $stable(cnt_ext[g]));
  end

  a_r11_off_zero: assert property (@(posedge clk) disable iff (rst)
    !ref_en |=> (ref_cnt == '0));

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (ref_en && !tick_ref) |=> $stable(ref_cnt));

  a_r11_steps_one: assert property (@(posedge clk) disable iff (rst)
    (ref_en && tick_ref) |=> (ref_cnt == $past(ref_cnt) + 1'b1));

endmodule

bind tick_timer_bank tmr_bank_checks #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .REF_W  (REF_W)
) u_checks (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .tick_ref (tick_ref),
  .irq      (irq),
  .uflow    (uflow),
  .chan_en  (chan_en),
  .cnt_ext  (cnt_ext),
  .ref_en   (ref_en),
  .ref_cnt  (ref_cnt)
);

// File: tb/test_tick_timer_bank.sv
`timescale 1ns/100ps
module test_tick_timer_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  a   = '0;
  logic        we  = 1'b0;
  logic [31:0] wd  = '0;
  logic [31:0] rd;
  logic        ts = 1'b0, tf = 1'b0, tr = 1'b0;
  logic [2:0]  irq;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tick_timer_bank i_tick_timer_bank (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (a),
    .bus_we    (we),
    .bus_wdata (wd),
    .bus_rdata (rd),
    .tick_slow (ts),
    .tick_fast (tf),
    .tick_ref  (tr),
    .irq       (irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog: got cycle %0d expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] addr, logic [31:0] data);
    @(negedge clk);
    a = addr; we = 1'b1; wd = data;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] addr, output logic [31:0] data);
    @(negedge clk);
    a = addr; we = 1'b0;
    @(negedge clk);
    data = rd;
  endtask

  task automatic pulse(bit s, bit f, bit r);
    @(negedge clk);
    ts = s; tf = f; tr = r;
    @(negedge clk);
    ts = 1'b0; tf = 1'b0; tr = 1'b0;
  endtask

  // count expected after n selected ticks from start value ld in a w-bit channel
  function automatic logic [31:0] exp_val(int w, longint ld, int n, bit per);
    longint m;
    m = longint'(1) << w;
    if (n <= ld) return 32'(ld - n);
    if (per)     return 32'(ld - ((n - ld - 1) % (ld + 1)));
    return 32'((m - 1) - ((longint'(n) - ld - 1) % m));
  endfunction

  function automatic int width_of(int ch);
    return (ch == 2) ? 32 : 16;
  endfunction

  function automatic logic [7:0] base_of(int ch);
    return (ch == 0) ? 8'h00 : (ch == 1) ? 8'h20 : 8'h80;
  endfunction

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7151));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int ch = 0; ch < 3; ch++) begin
      bus_rd(base_of(ch) + 8'h0, v); chk("R1 load reset", v, 32'h0);
      bus_rd(base_of(ch) + 8'h4, v); chk("R1 value reset", v, 32'h0);
      bus_rd(base_of(ch) + 8'h8, v); chk("R1 ctrl reset", v, 32'h0);
    end
    bus_rd(8'h60, v); chk("R1 ref low reset", v, 32'h0);
    bus_rd(8'h64, v); chk("R1 ref high reset", v, 32'h0);
    chk("R1 irq reset", {29'h0, irq}, 32'h0);
    bus_rd(8'h40, v); chk("R2 unmapped reads zero", v, 32'h0);

    // R11 reference counter
    repeat (5) pulse(1'b0, 1'b0, 1'b1);
    bus_rd(8'h60, v); chk("R11 disabled stays zero", v, 32'h0);
    bus_wr(8'h64, 32'h0000_01FF);
    repeat (7) pulse(1'b0, 1'b0, 1'b1);
    bus_rd(8'h60, v); chk("R11 low word counts", v, 32'd7);
    bus_rd(8'h64, v); chk("R11 high word and enable", v, 32'h0000_0100);
    chk("R11 no interrupt", {29'h0, irq}, 32'h0);
    bus_wr(8'h64, 32'h0);
    bus_rd(8'h60, v); chk("R11 disable clears", v, 32'h0);
    bus_rd(8'h64, v); chk("R11 enable reads back clear", v, 32'h0);

    // R3 width masking
    bus_wr(8'h00, 32'hABCD_1234);
    bus_rd(8'h00, v); chk("R3 narrow load masked", v, 32'h0000_1234);
    bus_rd(8'h04, v); chk("R3 narrow value masked", v, 32'h0000_1234);
    bus_wr(8'h80, 32'hABCD_1234);
    bus_rd(8'h84, v); chk("R3 wide value full", v, 32'hABCD_1234);

    // R8 load behaviour on channel 2, periodic, slow tick
    bus_wr(8'h28, 32'h0);
    bus_wr(8'h20, 32'd10);
    bus_rd(8'h24, v); chk("R8 disabled load copies", v, 32'd10);
    bus_wr(8'h28, 32'h0000_00C0);
    bus_rd(8'h28, v); chk("R2 ctrl readback", v, 32'h0000_00C0);
    repeat (3) pulse(1'b1, 1'b0, 1'b0);
    bus_rd(8'h24, v); chk("R4 decrement per tick", v, 32'd7);
    bus_wr(8'h20, 32'd50);
    bus_rd(8'h24, v); chk("R8 enabled load deferred", v, 32'd7);
    pulse(1'b1, 1'b0, 1'b0);
    bus_rd(8'h24, v); chk("R8 next tick loads", v, 32'd50);
    pulse(1'b1, 1'b0, 1'b0);
    bus_rd(8'h24, v); chk("R4 counts after reload", v, 32'd49);
    bus_wr(8'h24, 32'h0000_1234);
    bus_rd(8'h24, v); chk("R10 value write ignored", v, 32'd49);
    repeat (3) pulse(1'b0, 1'b1, 1'b0);
    bus_rd(8'h24, v); chk("R5 unselected tick ignored", v, 32'd49);
    bus_wr(8'h28, 32'h0);
    repeat (2) pulse(1'b1, 1'b1, 1'b0);
    bus_rd(8'h24, v); chk("R4 disabled holds", v, 32'd49);

    // R7 free-mode wrap on both widths
    bus_wr(8'h88, 32'h0);
    bus_wr(8'h80, 32'h0);
    bus_wr(8'h8C, 32'h0);
    bus_wr(8'h88, 32'h0000_0088);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R7 wide underflow irq", {31'h0, irq[2]}, 32'h1);
    bus_rd(8'h84, v); chk("R7 wide wraps to ones", v, 32'hFFFF_FFFF);
    pulse(1'b0, 1'b1, 1'b0);
    bus_rd(8'h84, v); chk("R7 wide continues down", v, 32'hFFFF_FFFE);
    bus_wr(8'h88, 32'h0);
    bus_wr(8'h8C, 32'h0);
    bus_wr(8'h08, 32'h0);
    bus_wr(8'h00, 32'h0);
    bus_wr(8'h08, 32'h0000_0080);
    pulse(1'b1, 1'b0, 1'b0);
    bus_rd(8'h04, v); chk("R7 narrow wraps to ones", v, 32'h0000_FFFF);

    // R9 sticky interrupt and clear priority on channel 1
    bus_wr(8'h08, 32'h0);
    bus_wr(8'h00, 32'h0);
    bus_wr(8'h0C, 32'h0);
    chk("R9 cleared before test", {31'h0, irq[0]}, 32'h0);
    bus_wr(8'h08, 32'h0000_00C8);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R6 periodic underflow irq", {31'h0, irq[0]}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R9 irq sticky", {31'h0, irq[0]}, 32'h1);
    @(negedge clk);
    a = 8'h0C; we = 1'b1; wd = $urandom; tf = 1'b1;
    @(negedge clk);
    we = 1'b0; tf = 1'b0;
    chk("R9 underflow beats clear", {31'h0, irq[0]}, 32'h1);
    bus_rd(8'h04, v); chk("R6 reload of zero", v, 32'h0);
    bus_wr(8'h0C, 32'h0000_DEAD);
    chk("R9 any value clears", {31'h0, irq[0]}, 32'h0);
    bus_wr(8'h08, 32'h0);

    // random trials: R4 R5 R6 R7
    for (int t = 0; t < 40; t++) begin
      int          ch;
      int          n;
      bit          per;
      bit          sel;
      longint      ld;
      logic [31:0] raw;
      logic [31:0] mask;
      ch   = int'($urandom % 3);
      per  = 1'($urandom);
      sel  = 1'($urandom);
      n    = int'($urandom % 45);
      raw  = ($urandom % 4 == 0) ? $urandom : ($urandom % 20);
      mask = (width_of(ch) == 32) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      ld   = longint'(raw & mask);
      if (ld > 64) n = n % 20;
      bus_wr(base_of(ch) + 8'h8, 32'h0);
      bus_wr(base_of(ch) + 8'h0, raw);
      bus_wr(base_of(ch) + 8'hC, $urandom);
      bus_wr(base_of(ch) + 8'h8, {24'h0, 1'b1, per, 2'b00, sel, 3'b000});
      for (int k = 0; k < n; k++) begin
        bit other;
        other = 1'($urandom);
        if (sel) pulse(other, 1'b1, 1'b0);
        else     pulse(1'b1, other, 1'b0);
      end
      chk(per ? "R6 random irq" : "R7 random irq", {31'h0, irq[ch]},
          {31'h0, (longint'(n) > ld)});
      bus_rd(base_of(ch) + 8'h4, v);
      chk(per ? "R6 R5 random count" : "R7 R5 random count", v,
          exp_val(width_of(ch), ld, n, per));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule